// File: doc/BRIEF.md
# Stack Register File Controller

This block holds eight data registers that are reached through a rotating top pointer rather than by fixed address. Every operand name is relative: ST(0) is the register the pointer currently selects, and ST(i) is the register i places below it. Each cycle it accepts one command. The commands are:

- a push, either from the data input or of a small built-in constant;
- a store of the top entry, with or without popping it;
- an exchange of the top with ST(n);
- a family of two-operand integer operations.

The two-operand operations come in four forms:

- **Classical-stack form:** the implied operands are ST(1) and ST(0).
- **Memory form:** ST(0) is combined with a value on the data input.
- **Register forms:** the destination is either ST(0) or ST(n).
- **Register-pop form:** the result is written to ST(n) and the stack is then popped.

A reversed-subtract selector swaps the two operand roles in every form.

Each physical register carries a valid tag. Pushing into an occupied slot raises a sticky overflow flag. Reading an empty slot raises a sticky underflow flag. A faulting command changes no register, tag or pointer. An initialize command empties the stack, returns the pointer to zero and clears both flags.

Top module: `stk_regfile`

## Requirements
- R1: After reset, and one cycle after an initialize command (cmd_op=1), top_ptr is 0, tag_o is all zero, and ovf_flag and unf_flag are 0.
- R2: A push moves the top pointer down by one modulo 8, sets the tag of the new top, and makes the pushed value ST(0). There are two push commands: cmd_op=2 pushes din, and cmd_op=3 pushes the constant equal to idx zero-extended (for example 0 or 1). ST(i) is physical register (top_ptr+i) mod 8.
- R3: A push whose target slot (top_ptr-1) mod 8 is already tagged sets ovf_flag and leaves the registers, tags and pointer unchanged. ovf_flag then stays set until an initialize.
- R4: A command that reads an empty ST(0) or ST(n) sets unf_flag. It writes nothing, moves nothing and produces no output. unf_flag stays set until an initialize.
- R5: A store (cmd_op=4) drives ST(0) on dout with dout_valid high in the cycle after the command. Store-and-pop (cmd_op=5) does the same, then clears that slot's tag and moves the pointer up by one.
- R6: An exchange (cmd_op=6) swaps ST(0) and ST(idx).
- R7: The classical-stack form (cmd_op=7) computes ST(1) op ST(0), writes the result to ST(1) and pops, so the result becomes the new ST(0).
- R8: The memory form (cmd_op=8) computes ST(0) op din and writes the result to ST(0).
- R9: There are two register forms, and neither moves the pointer. cmd_op=9 computes ST(idx) op ST(0) into ST(idx). cmd_op=10 computes ST(0) op ST(idx) into ST(0).
- R10: The register-pop form (cmd_op=11) computes ST(idx) op ST(0) into ST(idx) and then pops.
- R11: The operation is selected by alu_op. Taking the first-named operand as a and the other as b: 0 gives a+b, 1 gives a-b, 2 gives b-a, and 3 gives a+b. All results wrap modulo 2^DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 4 | Command code; 0 is no operation |
| alu_op | input | 2 | Operation select for the two-operand forms |
| idx | input | 3 | Stack index n, or the constant for a constant push |
| din | input | DATA_W | Push data or memory-form operand |
| dout | output | DATA_W | Stored ST(0) value |
| dout_valid | output | 1 | dout holds a store result this cycle |
| top_ptr | output | 3 | Current top-of-stack physical index |
| tag_o | output | 8 | Valid tag of each physical register |
| ovf_flag | output | 1 | Sticky stack overflow |
| unf_flag | output | 1 | Sticky stack underflow |

## Verification
The assertions check the following on every cycle:

- the pointer and tag movement of pushes and store-and-pop;
- the freeze on overflow and on underflow;
- the stickiness of both flags;
- the clearing action of initialize.

The data contents of the stack are not visible to them. The scenarios therefore check the following through stored values:

- operand order of every arithmetic form and of reversed subtract;
- wrap-around results;
- exchange;
- that a register form leaves its other operand intact.

// File: rtl/stk_pkg.sv
// Package: command and operation codes shared by the stack register file.
// Assumes the codes are driven on plain 4-bit and 2-bit ports.
package stk_pkg;
    typedef enum logic [3:0] {
        CMD_NOP    = 4'd0,
        CMD_INIT   = 4'd1,
        CMD_PUSH   = 4'd2,
        CMD_PUSHK  = 4'd3,
        CMD_STORE  = 4'd4,
        CMD_STOREP = 4'd5,
        CMD_XCHG   = 4'd6,
        CMD_STK    = 4'd7,
        CMD_MEM    = 4'd8,
        CMD_REGN   = 4'd9,
        CMD_REG0   = 4'd10,
        CMD_REGP   = 4'd11
    } cmd_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_SUB  = 2'd1,
        ALU_SUBR = 2'd2,
        ALU_ADD2 = 2'd3
    } alu_e;
endpackage

// File: rtl/stk_alu.sv
// Module: integer operation unit for the stack forms.
// a is the first-named (destination) operand and b the other one.
// Purely combinational; all results wrap at DATA_W bits.
module stk_alu #(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    import stk_pkg::*;

    // Select the result of the requested operation.
    always_comb begin
        case (alu_e'(op))
            ALU_SUB:  y = a - b;
            ALU_SUBR: y = b - a;
            default:  y = a + b;
        endcase
    end
endmodule

// File: rtl/stk_regbank.sv
// Module: physical register storage with two combinational read ports
// and two write ports. Write port 1 wins when both ports address one cell.
// Assumes DEPTH is a power of two.
module stk_regbank #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  ra0,
    input  logic [PTR_W-1:0]  ra1,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1,
    input  logic              we0,
    input  logic [PTR_W-1:0]  wa0,
    input  logic [DATA_W-1:0] wd0,
    input  logic              we1,
    input  logic [PTR_W-1:0]  wa1,
    input  logic [DATA_W-1:0] wd1
);
    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [DATA_W-1:0] cell_q;

        // Hold one register; port 1 takes priority over port 0.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= '0;
            else if (we1 && wa1 == PTR_W'(i))
                cell_q <= wd1;
            else if (we0 && wa0 == PTR_W'(i))
                cell_q <= wd0;
        end

        assign cells[i] = cell_q;
    end

    assign rd0 = cells[ra0];
    assign rd1 = cells[ra1];
endmodule

// File: rtl/stk_tagtrack.sv
// Module: top pointer, per-register valid tags and sticky fault flags.
// Assumes the caller asserts push and pop only for commands that passed
// their checks, and never both together. init overrides everything else.
module stk_tagtrack #(
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             push,
    input  logic             pop,
    input  logic             set_ovf,
    input  logic             set_unf,
    output logic [PTR_W-1:0] top_o,
    output logic [DEPTH-1:0] tags_o,
    output logic             ovf_o,
    output logic             unf_o
);
    logic [PTR_W-1:0] top_q;
    logic [DEPTH-1:0] tags_q;
    logic             ovf_q;
    logic             unf_q;
    logic [PTR_W-1:0] top_dn;
    logic [PTR_W-1:0] top_up;

    assign top_dn = top_q - PTR_W'(1);
    assign top_up = top_q + PTR_W'(1);

    // Move the pointer and the tags for accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            top_q  <= '0;
            tags_q <= '0;
        end else if (push) begin
            top_q          <= top_dn;
            tags_q[top_dn] <= 1'b1;
        end else if (pop) begin
            top_q         <= top_up;
            tags_q[top_q] <= 1'b0;
        end
    end

    // Keep the overflow and underflow flags until an initialize.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_q | set_ovf;
            unf_q <= unf_q | set_unf;
        end
    end

    assign top_o  = top_q;
    assign tags_o = tags_q;
    assign ovf_o  = ovf_q;
    assign unf_o  = unf_q;
endmodule

// File: rtl/stk_regfile.sv
// Module: stack-addressed register file controller. It decodes one command
// per cycle, maps the relative names ST(i) to physical registers through the
// top pointer, and checks tags before anything is committed. A faulting
// command only raises its flag. Store results are registered, so they appear
// one cycle after the command.
module stk_regfile #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_op,
    input  logic [1:0]        alu_op,
    input  logic [PTR_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic [PTR_W-1:0]  top_ptr,
    output logic [DEPTH-1:0]  tag_o,
    output logic              ovf_flag,
    output logic              unf_flag
);
    import stk_pkg::*;

    cmd_e              cmd;
    logic [PTR_W-1:0]  nsel;
    logic [PTR_W-1:0]  p_top;
    logic [PTR_W-1:0]  p_n;
    logic [PTR_W-1:0]  p_new;
    logic [DATA_W-1:0] st0;
    logic [DATA_W-1:0] stn;
    logic [DATA_W-1:0] op_a;
    logic [DATA_W-1:0] op_b;
    logic [DATA_W-1:0] alu_y;
    logic              need0;
    logic              needn;
    logic              want_push;
    logic              want_pop;
    logic              want_out;
    logic              w0_req;
    logic              w1_req;
    logic [PTR_W-1:0]  w0_addr;
    logic [PTR_W-1:0]  w1_addr;
    logic [DATA_W-1:0] w0_data;
    logic [DATA_W-1:0] w1_data;
    logic              hit_unf;
    logic              hit_ovf;
    logic              ok;

    assign cmd   = cmd_e'(cmd_op);
    assign nsel  = (cmd == CMD_STK) ? PTR_W'(1) : idx;
    assign p_top = top_ptr;
    assign p_n   = top_ptr + nsel;
    assign p_new = top_ptr - PTR_W'(1);

    // Decode the command into reads, operand routing, writes and stack motion.
    always_comb begin
        need0     = 1'b0;
        needn     = 1'b0;
        want_push = 1'b0;
        want_pop  = 1'b0;
        want_out  = 1'b0;
        w0_req    = 1'b0;
        w1_req    = 1'b0;
        w0_addr   = p_top;
        w1_addr   = p_n;
        w0_data   = alu_y;
        w1_data   = alu_y;
        op_a      = st0;
        op_b      = stn;
        case (cmd)
            CMD_PUSH: begin
                want_push = 1'b1;
                w0_req    = 1'b1;
                w0_addr   = p_new;
                w0_data   = din;
            end
            CMD_PUSHK: begin
                want_push = 1'b1;
                w0_req    = 1'b1;
                w0_addr   = p_new;
                w0_data   = DATA_W'(idx);
            end
            CMD_STORE: begin
                need0    = 1'b1;
                want_out = 1'b1;
            end
            CMD_STOREP: begin
                need0    = 1'b1;
                want_out = 1'b1;
                want_pop = 1'b1;
            end
            CMD_XCHG: begin
                need0   = 1'b1;
                needn   = 1'b1;
                w0_req  = 1'b1;
                w0_data = stn;
                w1_req  = 1'b1;
                w1_data = st0;
            end
            CMD_STK, CMD_REGP: begin
                need0    = 1'b1;
                needn    = 1'b1;
                op_a     = stn;
                op_b     = st0;
                w1_req   = 1'b1;
                want_pop = 1'b1;
            end
            CMD_MEM: begin
                need0  = 1'b1;
                op_b   = din;
                w0_req = 1'b1;
            end
            CMD_REGN: begin
                need0  = 1'b1;
                needn  = 1'b1;
                op_a   = stn;
                op_b   = st0;
                w1_req = 1'b1;
            end
            CMD_REG0: begin
                need0  = 1'b1;
                needn  = 1'b1;
                w0_req = 1'b1;
            end
            default: ;
        endcase
    end

    assign hit_unf = (need0 && !tag_o[p_top]) || (needn && !tag_o[p_n]);
    assign hit_ovf = want_push && tag_o[p_new];
    assign ok      = !hit_unf && !hit_ovf;

    stk_regbank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .ra0   (p_top),
        .ra1   (p_n),
        .rd0   (st0),
        .rd1   (stn),
        .we0   (w0_req && ok),
        .wa0   (w0_addr),
        .wd0   (w0_data),
        .we1   (w1_req && ok),
        .wa1   (w1_addr),
        .wd1   (w1_data)
    );

    stk_alu #(.DATA_W(DATA_W)) u_alu (
        .op (alu_op),
        .a  (op_a),
        .b  (op_b),
        .y  (alu_y)
    );

    stk_tagtrack #(.DEPTH(DEPTH)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (cmd == CMD_INIT),
        .push    (want_push && ok),
        .pop     (want_pop && ok),
        .set_ovf (hit_ovf),
        .set_unf (hit_unf),
        .top_o   (top_ptr),
        .tags_o  (tag_o),
        .ovf_o   (ovf_flag),
        .unf_o   (unf_flag)
    );

    // Register the store result and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= want_out && ok;
            if (want_out && ok)
                dout <= st0;
        end
    end
endmodule

// File: rtl/stk_regfile_chk.sv
// Module: assertion checker for the stack register file, bound to the top.
// It observes ports only and relates commands to the pointer, tag and flag
// state one cycle later.
module stk_regfile_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cmd_op,
    input logic [1:0]        alu_op,
    input logic [PTR_W-1:0]  idx,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              dout_valid,
    input logic [PTR_W-1:0]  top_ptr,
    input logic [DEPTH-1:0]  tag_o,
    input logic              ovf_flag,
    input logic              unf_flag
);
    import stk_pkg::*;

    logic [PTR_W-1:0] below;
    logic             is_push;
    logic             is_store;

    assign below    = top_ptr - PTR_W'(1);
    assign is_push  = (cmd_op == CMD_PUSH) || (cmd_op == CMD_PUSHK);
    assign is_store = (cmd_op == CMD_STORE) || (cmd_op == CMD_STOREP);

    p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == CMD_INIT) |=> (top_ptr == '0 && tag_o == '0 && !ovf_flag && !unf_flag));

    p_push_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_push && !tag_o[below]) |=> (top_ptr == $past(below) && tag_o[top_ptr] && !dout_valid));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_push && tag_o[below]) |=> (ovf_flag && $stable(top_ptr) && $stable(tag_o)));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && cmd_op != CMD_INIT) |=> ovf_flag);

    p_unf_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && !tag_o[top_ptr]) |=> (unf_flag && !dout_valid && $stable(top_ptr) && $stable(tag_o)));

    p_unf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && cmd_op != CMD_INIT) |=> unf_flag);

    p_storep_pops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == CMD_STOREP && tag_o[top_ptr]) |=>
            (dout_valid && top_ptr == PTR_W'($past(top_ptr) + PTR_W'(1)) && $countones(tag_o) == $countones($past(tag_o)) - 1));

    p_store_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == CMD_STORE && tag_o[top_ptr]) |=> (dout_valid && $stable(top_ptr) && $stable(tag_o)));
endmodule

bind stk_regfile stk_regfile_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_op     (cmd_op),
    .alu_op     (alu_op),
    .idx        (idx),
    .din        (din),
    .dout       (dout),
    .dout_valid (dout_valid),
    .top_ptr    (top_ptr),
    .tag_o      (tag_o),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag)
);

// File: tb/stk_regfile_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard for the stack register file. Scenario tasks queue the
// store values the requirements predict; a monitor compares each dout_valid
// beat against the head of the queue. Pointer, tag and flag checks are made
// at the falling edge after a command has taken effect.
module stk_regfile_bench;
    import stk_pkg::*;

    localparam int DATA_W = 16;
    localparam int DEPTH  = 8;
    localparam int PTR_W  = $clog2(DEPTH);

    typedef struct {
        logic [DATA_W-1:0] val;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        cmd_op = 4'd0;
    logic [1:0]        alu_op = 2'd0;
    logic [PTR_W-1:0]  idx = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_valid;
    logic [PTR_W-1:0]  top_ptr;
    logic [DEPTH-1:0]  tag_o;
    logic              ovf_flag;
    logic              unf_flag;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb_q[$];

    stk_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stk_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_op     (cmd_op),
        .alu_op     (alu_op),
        .idx        (idx),
        .din        (din),
        .dout       (dout),
        .dout_valid (dout_valid),
        .top_ptr    (top_ptr),
        .tag_o      (tag_o),
        .ovf_flag   (ovf_flag),
        .unf_flag   (unf_flag)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input cmd_e c, input logic [1:0] a, input logic [PTR_W-1:0] n,
                         input logic [DATA_W-1:0] d);
        @(negedge clk);
        cmd_op = c;
        alu_op = a;
        idx    = n;
        din    = d;
    endtask

    task automatic settle();
        @(negedge clk);
        cmd_op = CMD_NOP;
    endtask

    task automatic expect_out(input cmd_e c, input logic [DATA_W-1:0] v, input string req);
        exp_t e;
        e.val = v;
        e.req = req;
        sb_q.push_back(e);
        issue(c, 2'd0, '0, '0);
    endtask

    // Monitor: compare every store beat with the scoreboard head.
    always @(posedge clk) begin
        #1;
        if (rst_n && dout_valid) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL store-beat: actual=%0h expected=none", dout);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.req, dout, e.val);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 top", top_ptr, 0);
        chk("R1 tags", tag_o, 0);
        chk("R1 flags", {ovf_flag, unf_flag}, 0);
        chk("R1 dout_valid", dout_valid, 0);

        // R4: store from an empty stack faults and emits nothing
        issue(CMD_STORE, 0, 0, 0); settle();
        chk("R4 unf on empty store", unf_flag, 1);
        chk("R4 top frozen", top_ptr, 0);
        issue(CMD_INIT, 0, 0, 0); settle();
        chk("R1 init clears unf", unf_flag, 0);

        // R2, R7: classical subtract 5-3
        issue(CMD_PUSH, 0, 0, 16'd5);
        issue(CMD_PUSH, 0, 0, 16'd3); settle();
        chk("R2 top after two pushes", top_ptr, 6);
        chk("R2 tags after two pushes", tag_o, 8'hC0);
        issue(CMD_STK, ALU_SUB, 0, 0); settle();
        chk("R7 pop top", top_ptr, 7);
        chk("R7 pop tags", tag_o, 8'h80);
        expect_out(CMD_STORE, 16'd2, "R7 st1-st0");
        // R7, R11: classical reversed subtract 10-2
        issue(CMD_PUSH, 0, 0, 16'd10);
        issue(CMD_STK, ALU_SUBR, 0, 0);
        expect_out(CMD_STORE, 16'd8, "R11 reversed classical");

        // R8, R11: memory form with wrap, then reversed
        issue(CMD_MEM, ALU_ADD, 0, 16'hFFFF);
        expect_out(CMD_STORE, 16'd7, "R8 mem add wrap");
        issue(CMD_MEM, ALU_SUBR, 0, 16'd20);
        expect_out(CMD_STORE, 16'd13, "R8 mem reversed");

        // R2, R6, R5: constants, exchange, store-and-pop
        issue(CMD_PUSHK, 0, 3'd1, 0);
        issue(CMD_PUSHK, 0, 3'd4, 0);
        issue(CMD_XCHG, 0, 3'd2, 0);
        expect_out(CMD_STOREP, 16'd13, "R6 exchanged top");
        expect_out(CMD_STOREP, 16'd1, "R2 constant one");
        expect_out(CMD_STOREP, 16'd4, "R6 exchanged st2");
        settle();
        chk("R5 empty after pops top", top_ptr, 0);
        chk("R5 empty after pops tags", tag_o, 0);

        // R9, R10: register forms and register-pop
        issue(CMD_PUSH, 0, 0, 16'd100);
        issue(CMD_PUSH, 0, 0, 16'd30);
        issue(CMD_PUSH, 0, 0, 16'd7);
        issue(CMD_REG0, ALU_SUB, 3'd2, 0);
        expect_out(CMD_STORE, 16'hFFA3, "R9 st0=st0-st2");
        issue(CMD_REGN, ALU_SUB, 3'd1, 0);
        expect_out(CMD_STORE, 16'hFFA3, "R9 st0 kept by dest-n form");
        issue(CMD_REGP, ALU_ADD, 3'd2, 0); settle();
        chk("R10 pop top", top_ptr, 6);
        expect_out(CMD_STOREP, 16'd123, "R9 st1=st1-st0");
        expect_out(CMD_STOREP, 16'd7, "R10 st2=st2+st0 then pop");

        // R3: overflow after eight pushes
        issue(CMD_INIT, 0, 0, 0);
        for (int k = 1; k <= 8; k++) issue(CMD_PUSH, 0, 0, DATA_W'(k));
        settle();
        chk("R2 full top wraps", top_ptr, 0);
        chk("R2 full tags", tag_o, 8'hFF);
        chk("R3 no ovf yet", ovf_flag, 0);
        issue(CMD_PUSH, 0, 0, 16'd99); settle();
        chk("R3 ovf set", ovf_flag, 1);
        chk("R3 top frozen", top_ptr, 0);
        expect_out(CMD_STORE, 16'd8, "R3 top unchanged by overflow");
        settle(); settle();
        chk("R3 ovf sticky", ovf_flag, 1);
        issue(CMD_INIT, 0, 0, 0); settle();
        chk("R1 init clears ovf", ovf_flag, 0);
        chk("R1 init clears tags", tag_o, 0);

        // R4: arithmetic and exchange reading an empty ST(n)
        issue(CMD_PUSH, 0, 0, 16'd5);
        issue(CMD_STK, ALU_ADD, 0, 0); settle();
        chk("R4 unf on classical", unf_flag, 1);
        chk("R4 top frozen on classical", top_ptr, 7);
        chk("R4 tags frozen on classical", tag_o, 8'h80);
        expect_out(CMD_STORE, 16'd5, "R4 st0 unchanged");
        issue(CMD_INIT, 0, 0, 0);
        issue(CMD_PUSH, 0, 0, 16'd6);
        issue(CMD_XCHG, 0, 3'd3, 0); settle();
        chk("R4 unf on exchange", unf_flag, 1);
        expect_out(CMD_STORE, 16'd6, "R4 st0 unchanged by exchange");
        settle(); settle(); settle();

        n_checks++;
        if (sb_q.size() != 0) begin
            n_errors++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule